// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block turns a single clocked write request into a correctly timed write cycle on an external asynchronous static RAM with 512K words of 16 bits. A request carries a 19-bit word address, a 16-bit data word and two byte-lane enables. The block accepts it through a valid/ready handshake. It then drives the address bus, the active-low chip select, write enable and per-lane byte strobes, and the data bus with its own output-enable. When the whole write cycle has elapsed, it raises a one-cycle completion pulse.

Every phase length is a cycle count fixed at elaboration. Each count is the ceiling of a nanosecond minimum over the clock period, and never less than one cycle. The minima come from a speed-grade parameter: 0 selects the 55 ns grade, 1 the 70 ns grade and 2 the 100 ns grade. A mode parameter picks which strobe frames the write. In write-enable framing, chip select opens one cycle early and write enable carries the pulse. In chip-select framing, write enable opens one cycle early and chip select carries the pulse. In both modes the two strobes release on the same edge. The data bus is driven only after the memory's output turn-off time has passed since write enable fell. Address and data are held one extra cycle after the strobes release.

With the defaults (4 ns clock, 55 ns grade) the pulse lasts 12 cycles. The data-bus turn-off wait is 5 cycles, and a full bus cycle takes 15 cycles from the accepting edge.

Top module: `sram_wr_ctrl`

## Requirements
- R1: During and right after reset, req_ready is 1, done is 0, sram_cs_n, sram_we_n, sram_ub_n and sram_lb_n are all 1, and sram_dq_oe is 0.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle on. done is high for exactly one cycle, the TOTAL_CYC-th cycle after acceptance (15 by default), with req_ready still 0. req_ready is 1 in the cycle after done.
- R3: sram_addr equals the accepted address in every cycle where any strobe is low or the data bus is driven.
- R4: With write-enable framing (PULSE_BY_CS=0), sram_cs_n goes low in cycle 1 after acceptance. sram_we_n goes low in cycle 2 and stays low for PULSE_CYC cycles (12 by default). Both rise on the same edge.
- R5: With chip-select framing (PULSE_BY_CS=1), sram_we_n goes low in cycle 1. sram_cs_n goes low in cycle 2 and stays low for PULSE_CYC cycles. Both rise on the same edge.
- R6: req_be bit 1 enables the upper lane (sram_ub_n) and bit 0 the lower lane (sram_lb_n). An enabled lane strobe is low from cycle 1 through the last pulse cycle (13 cycles by default). A disabled lane strobe stays high.
- R7: sram_dq_oe rises only after write enable has been low for TURN_CYC full cycles: it rises in cycle 7 by default. It stays high through the one hold cycle after the strobes release (8 cycles by default). While it is high, sram_dq_out equals the accepted data.
- R8: A request with req_be equal to 0 asserts no strobe and never drives the data bus, yet still completes with done after TOTAL_CYC cycles.
- R9: A request presented while req_ready is 0 is ignored: sram_addr is unchanged and no extra bus cycle or done pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 19 | Word address of the write |
| req_data | input | 16 | Data word to write |
| req_be | input | 2 | Lane enables, bit 1 upper, bit 0 lower |
| done | output | 1 | One-cycle pulse at the end of the write cycle |
| sram_addr | output | 19 | Memory address bus |
| sram_cs_n | output | 1 | Memory chip select, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_ub_n | output | 1 | Upper byte strobe, active low |
| sram_lb_n | output | 1 | Lower byte strobe, active low |
| sram_dq_out | output | 16 | Data driven toward the memory |
| sram_dq_oe | output | 1 | Output-enable of the data bus driver |

## Verification
The completion pulse of one write and the arrival of the next request can fall in the same cycle. The bench provokes this by presenting each new request, with req_valid held high, while the previous write is still in progress, so the request waits across the done cycle. The scoreboard judges it in two ways. req_ready must still be low during done and high in the very next cycle, so the waiting request is accepted only then. The strobe and data-bus timing of that following write must match the expected cycle positions exactly, with the address of the new request.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_PULSE,
    PH_HOLD,
    PH_PAD
  } phase_e;

  typedef enum int unsigned {
    TM_CYCLE,
    TM_PULSE,
    TM_CS_END,
    TM_ADDR_END,
    TM_DATA_SETUP,
    TM_LANE_END,
    TM_TURN_OFF
  } tmsel_e;

  // Nanosecond minimum of one interval for a speed grade (0:55, 1:70, 2:100)
  function automatic int unsigned grade_ns(int unsigned grade, tmsel_e sel);
    int unsigned g;
    g = (grade > 2) ? 2 : grade;
    case (sel)
      TM_CYCLE:      grade_ns = (g == 0) ? 55 : (g == 1) ? 70 : 100;
      TM_PULSE:      grade_ns = (g == 0) ? 35 : (g == 1) ? 55 : 70;
      TM_CS_END:     grade_ns = (g == 0) ? 40 : (g == 1) ? 60 : 80;
      TM_ADDR_END:   grade_ns = (g == 0) ? 40 : (g == 1) ? 60 : 80;
      TM_DATA_SETUP: grade_ns = (g == 0) ? 25 : (g == 1) ? 30 : 40;
      TM_LANE_END:   grade_ns = (g == 0) ? 35 : (g == 1) ? 55 : 70;
      default:       grade_ns = 20;
    endcase
  endfunction

  // Ceiling division into clock cycles, at least one cycle
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    ns_to_cyc = (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    max_u = (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 12,
  parameter int unsigned TOTAL_CYC = 15,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned BE_W      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [BE_W-1:0]  req_be,
  output logic             ready,
  output logic             accept,
  output logic             done,
  output phase_e           phase_d,
  output logic [CNT_W-1:0] pcnt_d
);

  localparam logic [CNT_W-1:0] PULSE_L = CNT_W'(PULSE_CYC);
  localparam logic [CNT_W-1:0] TOTAL_L = CNT_W'(TOTAL_CYC);
  localparam logic [CNT_W-1:0] ONE_L   = CNT_W'(1);

  phase_e           phase_q;
  logic [CNT_W-1:0] pcnt_q;
  logic [CNT_W-1:0] tot_q;
  logic [CNT_W-1:0] tot_d;

  assign ready  = (phase_q == PH_IDLE);
  assign accept = ready && req_valid;
  assign done   = (phase_q == PH_PAD) && (tot_q == TOTAL_L);

  always_comb begin
    phase_d = phase_q;
    pcnt_d  = pcnt_q;
    tot_d   = tot_q;
    case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          tot_d   = ONE_L;
          pcnt_d  = '0;
          phase_d = (req_be != '0) ? PH_SETUP : PH_PAD;
        end
      end
      PH_SETUP: begin
        tot_d   = tot_q + ONE_L;
        pcnt_d  = ONE_L;
        phase_d = PH_PULSE;
      end
      PH_PULSE: begin
        tot_d = tot_q + ONE_L;
        if (pcnt_q == PULSE_L) begin
          phase_d = PH_HOLD;
        end else begin
          pcnt_d = pcnt_q + ONE_L;
        end
      end
      PH_HOLD: begin
        tot_d   = tot_q + ONE_L;
        phase_d = PH_PAD;
      end
      PH_PAD: begin
        if (tot_q == TOTAL_L) begin
          phase_d = PH_IDLE;
          tot_d   = '0;
        end else begin
          tot_d = tot_q + ONE_L;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      pcnt_q  <= '0;
      tot_q   <= '0;
    end else begin
      phase_q <= phase_d;
      pcnt_q  <= pcnt_d;
      tot_q   <= tot_d;
    end
  end

endmodule

// File: rtl/sram_wr_latch.sv
module sram_wr_latch #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BE_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [BE_W-1:0]   req_be,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic [BE_W-1:0]   lane_be
);

  logic [BE_W-1:0] be_q;

  // Lane enables seen by the strobe stage on the accepting edge come straight in
  assign lane_be = accept ? req_be : be_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr <= '0;
      bus_data <= '0;
      be_q     <= '0;
    end else if (accept) begin
      bus_addr <= req_addr;
      bus_data <= req_data;
      be_q     <= req_be;
    end
  end

endmodule

// File: rtl/sram_wr_strobe.sv
module sram_wr_strobe
  import sram_wr_pkg::*;
#(
  parameter bit          PULSE_BY_CS = 1'b0,
  parameter int unsigned TURN_CYC    = 5,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned BE_W        = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  phase_e           phase_d,
  input  logic [CNT_W-1:0] pcnt_d,
  input  logic [BE_W-1:0]  lane_be,
  output logic             cs_n,
  output logic             we_n,
  output logic [BE_W-1:0]  lane_n,
  output logic             dq_oe
);

  localparam logic [CNT_W-1:0] TURN_L = CNT_W'(TURN_CYC);

  logic lead, pulse, lanes_on, drive;

  assign lead     = (phase_d == PH_SETUP);
  assign pulse    = (phase_d == PH_PULSE);
  assign lanes_on = lead || pulse;
  assign drive    = (pulse && (pcnt_d > TURN_L)) || (phase_d == PH_HOLD);

  generate
    if (PULSE_BY_CS) begin : g_cs_frame
      always_ff @(posedge clk) begin
        if (rst) begin
          cs_n <= 1'b1;
          we_n <= 1'b1;
        end else begin
          cs_n <= !pulse;
          we_n <= !lanes_on;
        end
      end
    end else begin : g_we_frame
      always_ff @(posedge clk) begin
        if (rst) begin
          cs_n <= 1'b1;
          we_n <= 1'b1;
        end else begin
          cs_n <= !lanes_on;
          we_n <= !pulse;
        end
      end
    end
  endgenerate

  for (genvar i = 0; i < BE_W; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) lane_n[i] <= 1'b1;
      else     lane_n[i] <= !(lanes_on && lane_be[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dq_oe <= 1'b0;
    else     dq_oe <= drive;
  end

endmodule

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl
  import sram_wr_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned SPEED_GRADE   = 0,
  parameter bit          PULSE_BY_CS   = 1'b0,
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned DATA_W        = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [1:0]        req_be,
  output logic              done,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_ub_n,
  output logic              sram_lb_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe
);

  localparam int unsigned BE_W     = 2;
  localparam int unsigned WC_CYC   = ns_to_cyc(grade_ns(SPEED_GRADE, TM_CYCLE), CLK_PERIOD_NS);
  localparam int unsigned TURN_CYC = ns_to_cyc(grade_ns(SPEED_GRADE, TM_TURN_OFF), CLK_PERIOD_NS);
  localparam int unsigned DS_CYC   = ns_to_cyc(grade_ns(SPEED_GRADE, TM_DATA_SETUP), CLK_PERIOD_NS);
  localparam int unsigned WP_CYC   = ns_to_cyc(grade_ns(SPEED_GRADE, TM_PULSE), CLK_PERIOD_NS);
  localparam int unsigned CW_CYC   = ns_to_cyc(grade_ns(SPEED_GRADE, TM_CS_END), CLK_PERIOD_NS);
  localparam int unsigned AW_CYC   = ns_to_cyc(grade_ns(SPEED_GRADE, TM_ADDR_END), CLK_PERIOD_NS);
  localparam int unsigned BW_CYC   = ns_to_cyc(grade_ns(SPEED_GRADE, TM_LANE_END), CLK_PERIOD_NS);
  localparam int unsigned PULSE_CYC =
    max_u(max_u(max_u(WP_CYC, CW_CYC), max_u(AW_CYC, BW_CYC)), TURN_CYC + DS_CYC);
  localparam int unsigned TOTAL_CYC = max_u(WC_CYC, PULSE_CYC + 3);
  localparam int unsigned CNT_W     = $clog2(TOTAL_CYC + 1);

  logic             accept;
  phase_e           phase_d;
  logic [CNT_W-1:0] pcnt_d;
  logic [BE_W-1:0]  lane_be;
  logic [BE_W-1:0]  lane_n;

  sram_wr_seq #(
    .PULSE_CYC(PULSE_CYC),
    .TOTAL_CYC(TOTAL_CYC),
    .CNT_W    (CNT_W),
    .BE_W     (BE_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_be   (req_be),
    .ready    (req_ready),
    .accept   (accept),
    .done     (done),
    .phase_d  (phase_d),
    .pcnt_d   (pcnt_d)
  );

  sram_wr_latch #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .BE_W  (BE_W)
  ) u_latch (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept),
    .req_addr(req_addr),
    .req_data(req_data),
    .req_be  (req_be),
    .bus_addr(sram_addr),
    .bus_data(sram_dq_out),
    .lane_be (lane_be)
  );

  sram_wr_strobe #(
    .PULSE_BY_CS(PULSE_BY_CS),
    .TURN_CYC   (TURN_CYC),
    .CNT_W      (CNT_W),
    .BE_W       (BE_W)
  ) u_strobe (
    .clk    (clk),
    .rst    (rst),
    .phase_d(phase_d),
    .pcnt_d (pcnt_d),
    .lane_be(lane_be),
    .cs_n   (sram_cs_n),
    .we_n   (sram_we_n),
    .lane_n (lane_n),
    .dq_oe  (sram_dq_oe)
  );

  assign sram_ub_n = lane_n[1];
  assign sram_lb_n = lane_n[0];

endmodule

// File: rtl/sram_wr_chk.sv
module sram_wr_chk #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_be,
  input logic              done,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_cs_n,
  input logic              sram_we_n,
  input logic              sram_ub_n,
  input logic              sram_lb_n,
  input logic [DATA_W-1:0] sram_dq_out,
  input logic              sram_dq_oe
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> req_ready && !done && sram_cs_n && sram_we_n && sram_ub_n && sram_lb_n && !sram_dq_oe);

  // R2
  done_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_ready);

  // R2
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> req_ready && !done);

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);

  // R9
  busy_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> $stable(sram_addr));

  // R4
  we_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> sram_cs_n);

  // R5
  cs_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_cs_n) |-> sram_we_n);

  // R6
  lane_framed_chk: assert property (@(posedge clk) disable iff (rst)
    (!sram_ub_n || !sram_lb_n) |-> (!sram_cs_n || !sram_we_n));

  // R7
  oe_turnoff_chk: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe && !$past(sram_dq_oe) |-> !sram_we_n && !$past(sram_we_n));

  // R7
  data_steady_chk: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe && $past(sram_dq_oe) |-> $stable(sram_dq_out));

  // R8
  empty_lane_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && (req_be == 2'b00) |=> sram_cs_n && sram_we_n && sram_ub_n && sram_lb_n);

endmodule

bind sram_wr_ctrl sram_wr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_sram_wr_ctrl.sv
module tb_sram_wr_ctrl;

  typedef struct {
    logic [18:0] a;
    logic [15:0] d;
    logic [1:0]  be;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic [1:0]  req_be = '0;

  logic [1:0]  m_rdy, m_done, m_cs, m_we, m_ub, m_lb, m_oe;
  logic [18:0] m_addr [2];
  logic [15:0] m_dq   [2];

  int checks = 0;
  int errors = 0;
  int nsent = 0;
  int ndone = 0;
  bit finished = 0;
  item_t q[$];

  always #2 clk = ~clk;

  sram_wr_ctrl #(.CLK_PERIOD_NS(4), .SPEED_GRADE(0), .PULSE_BY_CS(1'b0)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(m_rdy[0]),
    .req_addr(req_addr), .req_data(req_data), .req_be(req_be), .done(m_done[0]),
    .sram_addr(m_addr[0]), .sram_cs_n(m_cs[0]), .sram_we_n(m_we[0]),
    .sram_ub_n(m_ub[0]), .sram_lb_n(m_lb[0]), .sram_dq_out(m_dq[0]), .sram_dq_oe(m_oe[0])
  );

  sram_wr_ctrl #(.CLK_PERIOD_NS(4), .SPEED_GRADE(0), .PULSE_BY_CS(1'b1)) dut_cs (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(m_rdy[1]),
    .req_addr(req_addr), .req_data(req_data), .req_be(req_be), .done(m_done[1]),
    .sram_addr(m_addr[1]), .sram_cs_n(m_cs[1]), .sram_we_n(m_we[1]),
    .sram_ub_n(m_ub[1]), .sram_lb_n(m_lb[1]), .sram_dq_out(m_dq[1]), .sram_dq_oe(m_oe[1])
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Driver: present request, wait for acceptance, push expectation
  task automatic send(input logic [18:0] a, input logic [15:0] d, input logic [1:0] be);
    item_t it;
    req_addr  = a;
    req_data  = d;
    req_be    = be;
    req_valid = 1'b1;
    while (!m_rdy[0]) @(negedge clk);
    it.a = a; it.d = d; it.be = be;
    q.push_back(it);
    nsent++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Present junk while busy (R9)
  task automatic poke();
    req_addr  = 19'h2AAAA;
    req_data  = 16'hDEAD;
    req_be    = 2'b11;
    req_valid = 1'b1;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor state, per instance
  int cyc[2], we_f[2], we_l[2], we_c[2], cs_f[2], cs_l[2], cs_c[2];
  int ub_c[2], lb_c[2], oe_f[2], oe_c[2], addr_bad[2], data_bad[2];
  bit after_done = 0;

  task automatic clear(input int d);
    cyc[d] = 0; we_f[d] = 0; we_l[d] = 0; we_c[d] = 0; cs_f[d] = 0; cs_l[d] = 0; cs_c[d] = 0;
    ub_c[d] = 0; lb_c[d] = 0; oe_f[d] = 0; oe_c[d] = 0; addr_bad[d] = 0; data_bad[d] = 0;
  endtask

  task automatic judge(input int d, input item_t it);
    string rq;
    int pf, pc, pl, ff, fc, fl;
    rq = (d == 0) ? "R4" : "R5";
    chk(cyc[d] == 15, "R2 done cycle", cyc[d], 15);
    if (it.be != 2'b00) begin
      pf = (d == 0) ? we_f[d] : cs_f[d];
      pc = (d == 0) ? we_c[d] : cs_c[d];
      pl = (d == 0) ? we_l[d] : cs_l[d];
      ff = (d == 0) ? cs_f[d] : we_f[d];
      fc = (d == 0) ? cs_c[d] : we_c[d];
      fl = (d == 0) ? cs_l[d] : we_l[d];
      chk(ff == 1, {rq, " framing strobe start"}, ff, 1);
      chk(fc == 13 && fl == 13, {rq, " framing strobe length"}, fc, 13);
      chk(pf == 2, {rq, " pulse start"}, pf, 2);
      chk(pc == 12 && pl == 13, {rq, " pulse length and joint release"}, pc, 12);
      chk(ub_c[d] == (it.be[1] ? 13 : 0), "R6 upper lane", ub_c[d], it.be[1] ? 13 : 0);
      chk(lb_c[d] == (it.be[0] ? 13 : 0), "R6 lower lane", lb_c[d], it.be[0] ? 13 : 0);
      chk(oe_f[d] == 7, "R7 data drive start", oe_f[d], 7);
      chk(oe_c[d] == 8, "R7 data drive length", oe_c[d], 8);
    end else begin
      chk(we_c[d] + cs_c[d] + ub_c[d] + lb_c[d] + oe_c[d] == 0, "R8 empty lanes quiet",
          we_c[d] + cs_c[d] + ub_c[d] + lb_c[d] + oe_c[d], 0);
    end
    chk(addr_bad[d] == 0, "R3 address held", addr_bad[d], 0);
    chk(data_bad[d] == 0, "R7 data value", data_bad[d], 0);
  endtask

  // Monitor: observe both instances away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (after_done) begin
        chk(m_rdy == 2'b11, "R2 ready after done", m_rdy, 3);
        after_done = 0;
      end
      for (int d = 0; d < 2; d++) begin
        if (!m_rdy[d]) begin
          cyc[d]++;
          if (!m_we[d]) begin if (we_c[d] == 0) we_f[d] = cyc[d]; we_l[d] = cyc[d]; we_c[d]++; end
          if (!m_cs[d]) begin if (cs_c[d] == 0) cs_f[d] = cyc[d]; cs_l[d] = cyc[d]; cs_c[d]++; end
          if (!m_ub[d]) ub_c[d]++;
          if (!m_lb[d]) lb_c[d]++;
          if (m_oe[d]) begin if (oe_c[d] == 0) oe_f[d] = cyc[d]; oe_c[d]++; end
          if (q.size() > 0 && (!m_cs[d] || !m_we[d] || !m_ub[d] || !m_lb[d] || m_oe[d])
              && m_addr[d] != q[0].a) addr_bad[d]++;
          if (q.size() > 0 && m_oe[d] && m_dq[d] != q[0].d) data_bad[d]++;
        end
      end
      if (m_done != 2'b00) begin
        item_t it;
        chk(m_done == 2'b11 && m_rdy == 2'b00, "R2 done with ready low", {m_done, m_rdy}, 12);
        if (q.size() > 0) begin
          it = q.pop_front();
          ndone++;
          judge(0, it);
          judge(1, it);
        end else begin
          chk(0, "R9 unexpected done", 1, 0);
        end
        clear(0);
        clear(1);
        after_done = 1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 1, 0);
    report();
  end

  initial begin
    clear(0);
    clear(1);
    repeat (4) @(negedge clk);
    // R1 while reset held
    chk(m_rdy == 2'b11 && m_done == 2'b00, "R1 handshake in reset", {m_rdy, m_done}, 12);
    chk(m_cs == 2'b11 && m_we == 2'b11 && m_ub == 2'b11 && m_lb == 2'b11 && m_oe == 2'b00,
        "R1 strobes in reset", {m_cs, m_we, m_ub, m_lb, m_oe}, 1020);
    rst = 1'b0;
    @(negedge clk);
    chk(m_rdy == 2'b11 && m_cs == 2'b11 && m_we == 2'b11 && m_oe == 2'b00,
        "R1 idle after reset", {m_rdy, m_cs, m_we, m_oe}, 252);

    // back-to-back writes with varied lanes and patterns (R2..R7)
    send(19'h7FFFF, 16'hA55A, 2'b11);
    send(19'h12345, 16'h0F0F, 2'b01);
    send(19'h00000, 16'hFFFF, 2'b10);
    // no lanes enabled (R8)
    send(19'h3C3C3, 16'h1234, 2'b00);
    // request arriving while busy must be ignored (R9)
    send(19'h55555, 16'h8001, 2'b11);
    poke();
    while (q.size() > 0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(ndone == nsent && m_rdy == 2'b11, "R9 no extra cycle from busy request", ndone, nsent);
    chk(m_addr[0] == 19'h55555 && m_addr[1] == 19'h55555, "R9 address unchanged",
        m_addr[0], 19'h55555);
    send(19'h00001, 16'h7E81, 2'b11);
    while (q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    report();
  end

endmodule